// File: doc/BRIEF.md
# Audio Stream Descriptor Register Block

This block holds the control and status registers of one stream of a multi-stream audio DMA engine. Software reaches it over a simple word-wide register bus. Each instance owns a fixed 32-byte window that its stream index selects, and a fixed bit of the global interrupt words.

The block keeps the stream's run and reset controls, interrupt enables, priority and stream tag. It also keeps the cyclic buffer length, the last valid descriptor index, the sample format and the 64-bit descriptor list base. The DMA data mover reads these values from the output pins and reports events back on pulse inputs. Those events set sticky status flags, which software clears by writing ones. Stream reset is a two-phase handshake that software observes through the same control bit.

The register bus carries no data stream, so it has no valid/ready pair. A write takes effect at the clock edge where it is sampled. A read is answered one cycle later with an acknowledge, and the block never applies back-pressure. The event, FIFO-ready and interrupt pins are plain level or pulse signals.

Top module: `sd_stream_regs`

## Requirements
- R1: The window base is byte address 0x80 + 0x20*IDX. Word-aligned accesses whose address bits above bit 4 match the base hit the window; any other access has no effect, and a read that misses returns bus_ack = 0 and data 0. Offsets inside the window: 0x00 control, 0x04 status, 0x08 buffer length, 0x0C last valid index, 0x10 format, 0x14 FIFO size, 0x18 descriptor base low, 0x1C descriptor base high. A hit read returns its data with bus_ack = 1 in the cycle after the read is sampled.
- R2: Control bits: [0] stream reset, [1] run, [4:2] interrupt enables for completion, FIFO error and descriptor error, [5] priority, [11:8] tag. A write drives run and prio in the next cycle, and control reads back the same fields.
- R3: A control write while run is already 1 leaves the tag unchanged. A write while run is 0 loads it.
- R4: After software writes reset = 1, the reset bit reads 0 until RST_LAT cycles have passed. With back-to-back reads starting in the cycle after the write, read number RST_LAT+1 is the first to return 1. Clearing the bit behaves the same way, ending at 0, and stream_rst follows the bit as read.
- R5: While the internal stream reset is active, every register except control reads 0 (status bits [2:0], buffer length, last valid index, format, descriptor base), and writes and events aimed at them are ignored.
- R6: Status bits [2:0] are set by the evt_ioc, evt_fifo_err and evt_desc_err pulses, in that order. They stay set until software writes 1 to them. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Status bit 5 reads the fifo_ready input.
- R8: int_word bit IDX is 1 exactly when glob_int_en[IDX] is 1 and some status flag is set whose enable bit is also set. All other bits of int_word are 0.
- R9: The FIFO size register reads FIFO_DEPTH-1.
- R10: Buffer length, last valid index (LVI_W bits), format (16 bits) and the two halves of the descriptor base read back what was written, and they drive cbl, lvi, fmt and bdl_base.
- R11: Writing control with run = 0 and all enables 0 drops run and int_word in the next cycle. A following status write of 0x7 clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address from the controller base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_ack | output | 1 | Read hit acknowledge, one cycle after the read |
| evt_ioc | input | 1 | Buffer completion event pulse |
| evt_fifo_err | input | 1 | FIFO error event pulse |
| evt_desc_err | input | 1 | Descriptor error event pulse |
| fifo_ready | input | 1 | FIFO ready level from the data mover |
| glob_int_en | input | NSTREAM | Global per-stream interrupt enables |
| int_word | output | NSTREAM | Interrupt summary, only bit IDX used |
| run | output | 1 | Stream run control |
| stream_rst | output | 1 | Internal stream reset active |
| tag | output | TAG_W | Stream tag |
| prio | output | 1 | Traffic priority |
| cbl | output | CBL_W | Cyclic buffer length |
| lvi | output | LVI_W | Last valid descriptor index |
| fmt | output | 16 | Stream format |
| bdl_base | output | 64 | Descriptor list base address |

## Verification
A register write takes effect at the edge that samples it, so outputs such as run, tag and cbl are checked 2 ns after that edge. A read result is registered and is checked 2 ns after the edge that sampled the read. Event pulses set flags at the sampling edge, and the combinational int_word is checked 2 ns later. The reset handshake is measured by polling with one read per cycle from the cycle after the write and counting the reads until the bit changes. That count must be exactly RST_LAT+1.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int WIN_BYTES = 32;
  localparam int WIN_FIRST = 'h80;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_STS  = 3'd1,
    OFS_CBL  = 3'd2,
    OFS_LVI  = 3'd3,
    OFS_FMT  = 3'd4,
    OFS_FSZ  = 3'd5,
    OFS_BDLO = 3'd6,
    OFS_BDHI = 3'd7
  } sd_ofs_e;

  localparam int NFLAG     = 3;
  localparam int STS_FRDY  = 5;
  localparam int CTL_SRST  = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_IE    = 2;
  localparam int CTL_PRIO  = 5;
  localparam int CTL_TAG   = 8;
endpackage

// File: rtl/sd_reset_seq.sv
module sd_reset_seq #(
  parameter int RST_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic held
);
  localparam int CW = $clog2(RST_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      cnt  <= '0;
    end else if (req == held) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      held <= req;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sd_status.sv
module sd_status #(
  parameter int NSTREAM = 8,
  parameter int IDX     = 1,
  parameter int NF      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic [NF-1:0]      evt,
  input  logic               w1c_en,
  input  logic [NF-1:0]      w1c_mask,
  input  logic [NF-1:0]      ie,
  input  logic [NSTREAM-1:0] glob_en,
  output logic [NF-1:0]      flags,
  output logic [NSTREAM-1:0] int_word
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clr_all) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (evt[i])                       flags[i] <= 1'b1;
        else if (w1c_en && w1c_mask[i])   flags[i] <= 1'b0;
      end
    end
  end

  assign pend = |(flags & ie);

  for (genvar g = 0; g < NSTREAM; g++) begin : g_int
    assign int_word[g] = (g == IDX) & glob_en[g] & pend;
  end
endmodule

// File: rtl/sd_stream_regs.sv
module sd_stream_regs
  import sd_pkg::*;
#(
  parameter int NSTREAM    = 8,
  parameter int IDX        = 1,
  parameter int ADDR_W     = 12,
  parameter int RST_LAT    = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int TAG_W      = 4,
  parameter int CBL_W      = 32,
  parameter int LVI_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ack,
  input  logic               evt_ioc,
  input  logic               evt_fifo_err,
  input  logic               evt_desc_err,
  input  logic               fifo_ready,
  input  logic [NSTREAM-1:0] glob_int_en,
  output logic [NSTREAM-1:0] int_word,
  output logic               run,
  output logic               stream_rst,
  output logic [TAG_W-1:0]   tag,
  output logic               prio,
  output logic [CBL_W-1:0]   cbl,
  output logic [LVI_W-1:0]   lvi,
  output logic [15:0]        fmt,
  output logic [63:0]        bdl_base
);
  localparam int          BASE    = WIN_FIRST + WIN_BYTES * IDX;
  localparam int          HI_W    = ADDR_W - 5;
  localparam logic [HI_W-1:0] BASE_HI = HI_W'(BASE >> 5);
  localparam logic [31:0] FSZ_VAL = 32'(FIFO_DEPTH - 1);

  logic          hit;
  sd_ofs_e       ofs;
  logic          wr_hit, rd_hit;
  logic          srst_req;
  logic [NFLAG-1:0] ie_q;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] evt;
  logic [31:0]   rd_mux;

  assign hit    = (bus_addr[ADDR_W-1:5] == BASE_HI) && (bus_addr[1:0] == 2'b00);
  assign ofs    = sd_ofs_e'(bus_addr[4:2]);
  assign wr_hit = bus_wr && hit;
  assign rd_hit = bus_rd && hit;
  assign evt    = {evt_desc_err, evt_fifo_err, evt_ioc} & {NFLAG{!stream_rst}};

  // control register: survives the stream reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_req <= 1'b0;
      run      <= 1'b0;
      ie_q     <= '0;
      prio     <= 1'b0;
      tag      <= '0;
    end else if (wr_hit && ofs == OFS_CTRL) begin
      srst_req <= bus_wdata[CTL_SRST];
      run      <= bus_wdata[CTL_RUN];
      ie_q     <= bus_wdata[CTL_IE +: NFLAG];
      prio     <= bus_wdata[CTL_PRIO];
      if (!run) tag <= bus_wdata[CTL_TAG +: TAG_W];
    end
  end

  // stream parameters: cleared while the stream reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbl      <= '0;
      lvi      <= '0;
      fmt      <= '0;
      bdl_base <= '0;
    end else if (stream_rst) begin
      cbl      <= '0;
      lvi      <= '0;
      fmt      <= '0;
      bdl_base <= '0;
    end else if (wr_hit) begin
      case (ofs)
        OFS_CBL:  cbl             <= bus_wdata[CBL_W-1:0];
        OFS_LVI:  lvi             <= bus_wdata[LVI_W-1:0];
        OFS_FMT:  fmt             <= bus_wdata[15:0];
        OFS_BDLO: bdl_base[31:0]  <= bus_wdata;
        OFS_BDHI: bdl_base[63:32] <= bus_wdata;
        default: ;
      endcase
    end
  end

  sd_reset_seq #(.RST_LAT(RST_LAT)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (srst_req),
    .held (stream_rst)
  );

  sd_status #(.NSTREAM(NSTREAM), .IDX(IDX), .NF(NFLAG)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (stream_rst),
    .evt     (evt),
    .w1c_en  (wr_hit && ofs == OFS_STS && !stream_rst),
    .w1c_mask(bus_wdata[NFLAG-1:0]),
    .ie      (ie_q),
    .glob_en (glob_int_en),
    .flags   (flags),
    .int_word(int_word)
  );

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_CTRL: begin
        rd_mux[CTL_SRST]            = stream_rst;
        rd_mux[CTL_RUN]             = run;
        rd_mux[CTL_IE +: NFLAG]     = ie_q;
        rd_mux[CTL_PRIO]            = prio;
        rd_mux[CTL_TAG +: TAG_W]    = tag;
      end
      OFS_STS: begin
        rd_mux[NFLAG-1:0] = flags;
        rd_mux[STS_FRDY]  = fifo_ready;
      end
      OFS_CBL:  rd_mux[CBL_W-1:0] = cbl;
      OFS_LVI:  rd_mux[LVI_W-1:0] = lvi;
      OFS_FMT:  rd_mux[15:0]      = fmt;
      OFS_FSZ:  rd_mux            = FSZ_VAL;
      OFS_BDLO: rd_mux            = bdl_base[31:0];
      OFS_BDHI: rd_mux            = bdl_base[63:32];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? rd_mux : 32'h0;
      bus_ack   <= rd_hit;
    end
  end
endmodule

// File: rtl/sd_stream_chk.sv
module sd_stream_chk #(
  parameter int NSTREAM = 8,
  parameter int IDX     = 1,
  parameter int TAG_W   = 4,
  parameter int CBL_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               held,
  input logic               req,
  input logic               run,
  input logic [TAG_W-1:0]   tag,
  input logic [2:0]         flags,
  input logic [2:0]         evt,
  input logic [CBL_W-1:0]   cbl,
  input logic [NSTREAM-1:0] int_word,
  input logic [NSTREAM-1:0] glob_int_en
);
  // R4
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held) |-> (held == $past(req)));

  // R5
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (cbl == '0));

  // R3
  tag_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(tag));

  // R6
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt) && !held) |=> ((flags & $past(evt)) == $past(evt)));

  // R8
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_word[IDX] |-> glob_int_en[IDX]);
endmodule

bind sd_stream_regs sd_stream_chk #(
  .NSTREAM(NSTREAM), .IDX(IDX), .TAG_W(TAG_W), .CBL_W(CBL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .held       (stream_rst),
  .req        (srst_req),
  .run        (run),
  .tag        (tag),
  .flags      (flags),
  .evt        ({evt_desc_err, evt_fifo_err, evt_ioc}),
  .cbl        (cbl),
  .int_word   (int_word),
  .glob_int_en(glob_int_en)
);

// File: tb/sim_sd_stream_regs.sv
module sim_sd_stream_regs;
  localparam int NSTREAM = 8, IDX = 1, ADDR_W = 12, RST_LAT = 4, FIFO_DEPTH = 64;
  localparam int BASE = 'h80 + 'h20 * IDX;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack;
  logic evt_ioc = 0, evt_fifo_err = 0, evt_desc_err = 0, fifo_ready = 0;
  logic [NSTREAM-1:0] glob_int_en = '0, int_word;
  logic run, stream_rst, prio;
  logic [3:0] tag;
  logic [31:0] cbl;
  logic [7:0] lvi;
  logic [15:0] fmt;
  logic [63:0] bdl_base;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  sd_stream_regs #(.NSTREAM(NSTREAM), .IDX(IDX), .ADDR_W(ADDR_W),
                   .RST_LAT(RST_LAT), .FIFO_DEPTH(FIFO_DEPTH)) u0 (.*);

  localparam logic [7:0]  V_OFS [6] = '{8'h08, 8'h0C, 8'h10, 8'h18, 8'h1C, 8'h0C};
  localparam logic [31:0] V_WR  [6] = '{32'hDEAD_BEEF, 32'h0000_0113, 32'hABCD_4011,
                                        32'h1000_0080, 32'h0000_00FF, 32'h0000_0007};
  localparam logic [31:0] V_EXP [6] = '{32'hDEAD_BEEF, 32'h0000_0013, 32'h0000_4011,
                                        32'h1000_0080, 32'h0000_00FF, 32'h0000_0007};

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2; bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); #2; bus_rd = 0; d = bus_rdata; ack = bus_ack;
  endtask

  task automatic poll_rst(input logic want, output int n);
    logic [31:0] d; logic a;
    n = 0;
    do begin
      rd(ADDR_W'(BASE), d, a);
      n++;
    end while (d[0] !== want && n < 300);
  endtask

  task automatic pulse(input logic [2:0] e, input logic w1c, input logic [31:0] m);
    @(negedge clk);
    {evt_desc_err, evt_fifo_err, evt_ioc} = e;
    if (w1c) begin bus_wr = 1; bus_addr = ADDR_W'(BASE + 4); bus_wdata = m; end
    @(posedge clk); #2;
    {evt_desc_err, evt_fifo_err, evt_ioc} = 3'b0; bus_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; logic a; int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // reset state
    chk("R2 reset run", {63'b0, run}, 64'd0);
    chk("R8 reset int", {56'b0, int_word}, 64'd0);
    rd(ADDR_W'(BASE), d, a);
    chk("R2 reset ctrl", {32'b0, d}, 64'd0);

    // table walk R10
    for (int i = 0; i < 6; i++) begin
      wr(ADDR_W'(BASE + V_OFS[i]), V_WR[i]);
      rd(ADDR_W'(BASE + V_OFS[i]), d, a);
      chk("R10 readback", {31'b0, a, d}, {31'b0, 1'b1, V_EXP[i]});
    end
    chk("R10 cbl out", {32'b0, cbl}, 64'hDEAD_BEEF);
    chk("R10 bdl out", bdl_base, 64'h0000_00FF_1000_0080);
    chk("R10 fmt out", {48'b0, fmt}, 64'h4011);

    // R9, R7
    rd(ADDR_W'(BASE + 'h14), d, a);
    chk("R9 fifo size", {32'b0, d}, 64'(FIFO_DEPTH - 1));
    fifo_ready = 1;
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R7 fifo ready", {32'b0, d}, 64'h20);
    fifo_ready = 0;

    // R1 misses
    wr(ADDR_W'(BASE + 'h20 + 8), 32'h1111_2222);
    chk("R1 other window", {32'b0, cbl}, 64'hDEAD_BEEF);
    rd(ADDR_W'(BASE + 'h20 + 8), d, a);
    chk("R1 miss read", {31'b0, a, d}, 64'd0);
    wr(ADDR_W'(BASE + 9), 32'h3333_4444);
    chk("R1 unaligned", {32'b0, cbl}, 64'hDEAD_BEEF);

    // R2, R3
    wr(ADDR_W'(BASE), 32'h0000_053E);
    chk("R2 run/prio", {62'b0, run, prio}, 64'd3);
    chk("R3 tag load", {60'b0, tag}, 64'h5);
    rd(ADDR_W'(BASE), d, a);
    chk("R2 ctrl read", {32'b0, d}, 64'h53E);
    wr(ADDR_W'(BASE), 32'h0000_093E);
    chk("R3 tag held while running", {60'b0, tag}, 64'h5);

    // R6, R8
    glob_int_en = 8'h02;
    pulse(3'b001, 0, 0);
    chk("R8 int on completion", {56'b0, int_word}, 64'h02);
    glob_int_en = 8'h00; #1;
    chk("R8 global enable off", {56'b0, int_word}, 64'h00);
    glob_int_en = 8'h02;
    pulse(3'b110, 0, 0);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R6 flags sticky", {32'b0, d}, 64'h7);
    pulse(3'b000, 1, 32'h1);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R6 w1c", {32'b0, d}, 64'h6);
    pulse(3'b010, 1, 32'h2);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R6 set wins", {32'b0, d}, 64'h6);

    // R11 stop
    wr(ADDR_W'(BASE), 32'h0000_0000);
    chk("R11 run off", {63'b0, run}, 64'd0);
    chk("R11 int off", {56'b0, int_word}, 64'd0);
    chk("R3 tag kept on stop", {60'b0, tag}, 64'h5);
    wr(ADDR_W'(BASE + 4), 32'h7);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R11 flags cleared", {32'b0, d}, 64'h0);
    wr(ADDR_W'(BASE), 32'h0000_0900);
    chk("R3 tag load when stopped", {60'b0, tag}, 64'h9);

    // R4, R5 reset handshake
    pulse(3'b001, 0, 0);
    wr(ADDR_W'(BASE), 32'h0000_0901);
    poll_rst(1'b1, n);
    chk("R4 enter poll count", 64'(n), 64'(RST_LAT + 1));
    chk("R4 stream_rst out", {63'b0, stream_rst}, 64'd1);
    rd(ADDR_W'(BASE + 8), d, a);
    chk("R5 cbl cleared", {32'b0, d}, 64'd0);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R5 flags cleared", {32'b0, d}, 64'd0);
    wr(ADDR_W'(BASE + 'h18), 32'h5555_0000);
    pulse(3'b111, 0, 0);
    rd(ADDR_W'(BASE + 'h18), d, a);
    chk("R5 write ignored", {32'b0, d}, 64'd0);
    rd(ADDR_W'(BASE + 4), d, a);
    chk("R5 events ignored", {32'b0, d}, 64'd0);
    rd(ADDR_W'(BASE), d, a);
    chk("R5 ctrl kept", {32'b0, d}, 64'h901);
    wr(ADDR_W'(BASE), 32'h0000_0900);
    poll_rst(1'b0, n);
    chk("R4 exit poll count", 64'(n), 64'(RST_LAT + 1));
    wr(ADDR_W'(BASE + 8), 32'h0000_0400);
    chk("R10 write after reset", {32'b0, cbl}, 64'h400);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule